// File: doc/BRIEF.md
# Serial Latch Programming Port

This block is the control port of a frequency synthesizer. A host writes 24-bit words through three pins: a serial clock, a serial data line and a load strobe. The three pins are asynchronous to the system clock. They are synchronized, and the bits are collected into a shift register. When the load strobe rises, the word is sent to one of four destination latches. The two lowest bits of the word choose the destination.

The destinations are:
- a reference divider latch.
- a counter latch, which holds the A value, the B value and a charge pump gain flag.
- a function latch, which holds the prescaler select, the power-down controls and two charge pump current codes. The current codes are stored and passed on; nothing else is done with them.
- an initialization alias of the function latch. A write to it loads the same function fields and also gives a one-cycle reset pulse to the reference counter and the A/B counter downstream.

Top module: `ser_latch_if`

## Requirements
- R1: On each rising edge of `ser_clk`, the bit on `ser_dat` is shifted into the input register at bit 0. Earlier bits move toward bit 23, so the first bit sent ends up in bit 23 (MSB first).
- R2: A load with control bits [1:0] = 00 copies word bits [15:2] to `r_div`.
- R3: A load with control bits [1:0] = 01 copies bits [7:2] to `a_cnt`, bits [20:8] to `b_cnt` and bit 21 to `cp_gain`.
- R4: A load with control bits [1:0] = 10 copies the function fields:
  - bit 2 to `pd_en` (1 = powered down).
  - bit 3 to `pd_async` (1 = asynchronous, 0 = synchronous power-down).
  - bits [6:4] to `cur_set1`.
  - bits [9:7] to `cur_set2`.
  - bits [23:22] to `presc_sel`.
- R5: A load with control bits [1:0] = 11 updates the same function fields as R4 and raises `cnt_rst`.
- R6: `cnt_rst` is high for exactly one system clock cycle for each initialization load. It stays low for every other load.
- R7: A load leaves every output field of the latches it does not address unchanged.
- R8: A word with fewer or more than 24 serial clocks before the load strobe latches the last 24 bits shifted in. With fewer than 24 clocks, the upper bits come from earlier traffic.
- R9: After reset, every output is zero.
- R10: Serial clocks with no load strobe rising edge change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, rising edge transfers word |
| r_div | output | 14 | Reference divide value |
| a_cnt | output | 6 | A counter value |
| b_cnt | output | 13 | B counter value |
| cp_gain | output | 1 | Charge pump gain flag |
| presc_sel | output | 2 | Prescaler select |
| pd_en | output | 1 | Power-down request |
| pd_async | output | 1 | Asynchronous power-down select |
| cur_set1 | output | 3 | Charge pump current code 1 |
| cur_set2 | output | 3 | Charge pump current code 2 |
| cnt_rst | output | 1 | One-cycle counter reset pulse |

## Verification
The bench sweeps a walking one through the reference field. It sweeps the A and B fields over many patterns, and runs all 16 combinations of prescaler select and power-down bits. After every load it compares all outputs, so a design that decodes the wrong latch, or writes a field into a neighbour latch, is caught.

The bench counts the `cnt_rst` cycles for each load. A pulse that is stretched, missing, or also raised on plain function writes shows up as a wrong count.

Short and long words check that the design keeps the last 24 bits rather than the first, and does not clear the register on a load. Clocking a word in without a strobe catches a design that latches on shifting alone.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int WORD_W = 24;
  localparam int R_W    = 14;
  localparam int A_W    = 6;
  localparam int B_W    = 13;
  localparam int CUR_W  = 3;
  localparam int PS_W   = 2;

  typedef enum logic [1:0] {
    SEL_REF  = 2'b00,
    SEL_CNT  = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } sel_e;

  // field positions (low bit of each field)
  localparam int R_LO     = 2;
  localparam int A_LO     = 2;
  localparam int B_LO     = 8;
  localparam int GAIN_BIT = 21;
  localparam int PD_BIT   = 2;
  localparam int ASY_BIT  = 3;
  localparam int C1_LO    = 4;
  localparam int C2_LO    = 7;
  localparam int PS_LO    = 22;

  typedef struct packed {
    logic [PS_W-1:0]  presc;
    logic             pd_en;
    logic             pd_async;
    logic [CUR_W-1:0] cur1;
    logic [CUR_W-1:0] cur2;
  } func_t;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           gain;
  } cnt_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign dout[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/word_shift.sv
module word_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_q[0] == $past(bit_in)) && (word_q[W-1:1] == $past(word_q[W-2:0])));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
endmodule

// File: rtl/latch_bank.sv
module latch_bank
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [R_W-1:0]    r_q,
  output cnt_t              cnt_q,
  output func_t             func_q,
  output logic              rst_pulse
);
  sel_e  sel;
  logic [R_W-1:0] r_d;
  cnt_t  cnt_d;
  func_t func_d, func_new;
  logic  pulse_d;

  assign sel = sel_e'(word[1:0]);

  always_comb begin
    func_new.presc    = word[PS_LO +: PS_W];
    func_new.pd_en    = word[PD_BIT];
    func_new.pd_async = word[ASY_BIT];
    func_new.cur1     = word[C1_LO +: CUR_W];
    func_new.cur2     = word[C2_LO +: CUR_W];
  end

  always_comb begin
    r_d     = r_q;
    cnt_d   = cnt_q;
    func_d  = func_q;
    pulse_d = 1'b0;
    if (load) begin
      unique case (sel)
        SEL_REF:  r_d = word[R_LO +: R_W];
        SEL_CNT: begin
          cnt_d.a    = word[A_LO +: A_W];
          cnt_d.b    = word[B_LO +: B_W];
          cnt_d.gain = word[GAIN_BIT];
        end
        SEL_FUNC: func_d = func_new;
        SEL_INIT: begin
          func_d  = func_new;
          pulse_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q       <= '0;
      cnt_q     <= '0;
      func_q    <= '0;
      rst_pulse <= 1'b0;
    end else begin
      r_q       <= r_d;
      cnt_q     <= cnt_d;
      func_q    <= func_d;
      rst_pulse <= pulse_d;
    end
  end

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  p_pulse_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(load));

  p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(r_q) && $stable(cnt_q) && $stable(func_q));
endmodule

// File: rtl/ser_latch_if.sv
module ser_latch_if
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  output logic [R_W-1:0]   r_div,
  output logic [A_W-1:0]   a_cnt,
  output logic [B_W-1:0]   b_cnt,
  output logic             cp_gain,
  output logic [PS_W-1:0]  presc_sel,
  output logic             pd_en,
  output logic             pd_async,
  output logic [CUR_W-1:0] cur_set1,
  output logic [CUR_W-1:0] cur_set2,
  output logic             cnt_rst
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] pins_s;
  logic            sclk_s, sdat_s, sle_s;
  logic            sclk_prev_q, sle_prev_q;
  logic            sclk_rise, sle_rise;
  logic [WORD_W-1:0] shreg;
  logic [R_W-1:0]  r_q;
  cnt_t            cnt_q;
  func_t           func_q;

  bit_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_le, ser_dat, ser_clk}),
    .dout (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign sdat_s = pins_s[1];
  assign sle_s  = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      sle_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      sle_prev_q  <= sle_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sle_rise  = sle_s & ~sle_prev_q;

  word_shift #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(sclk_rise),
    .bit_in  (sdat_s),
    .word    (shreg)
  );

  latch_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sle_rise),
    .word     (shreg),
    .r_q      (r_q),
    .cnt_q    (cnt_q),
    .func_q   (func_q),
    .rst_pulse(cnt_rst)
  );

  assign r_div     = r_q;
  assign a_cnt     = cnt_q.a;
  assign b_cnt     = cnt_q.b;
  assign cp_gain   = cnt_q.gain;
  assign presc_sel = func_q.presc;
  assign pd_en     = func_q.pd_en;
  assign pd_async  = func_q.pd_async;
  assign cur_set1  = func_q.cur1;
  assign cur_set2  = func_q.cur2;

  p_le_edge_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sle_rise |=> !sle_rise);

  p_ref_change_needs_le_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (r_div != $past(r_div)) |-> $past(sle_rise));
endmodule

// File: tb/sim_ser_latch_if.sv
module sim_ser_latch_if;
  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, ser_dat, ser_le;
  logic [13:0] r_div;
  logic [5:0]  a_cnt;
  logic [12:0] b_cnt;
  logic        cp_gain;
  logic [1:0]  presc_sel;
  logic        pd_en, pd_async;
  logic [2:0]  cur_set1, cur_set2;
  logic        cnt_rst;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  logic [23:0] m_sh;
  logic [13:0] e_r;
  logic [5:0]  e_a;
  logic [12:0] e_b;
  logic        e_g;
  logic [1:0]  e_ps;
  logic        e_pd, e_as;
  logic [2:0]  e_c1, e_c2;

  always #2.5 clk = ~clk;

  ser_latch_if u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .r_div(r_div), .a_cnt(a_cnt), .b_cnt(b_cnt), .cp_gain(cp_gain),
    .presc_sel(presc_sel), .pd_en(pd_en), .pd_async(pd_async),
    .cur_set1(cur_set1), .cur_set2(cur_set2), .cnt_rst(cnt_rst)
  );

  always @(negedge clk) if (cnt_rst) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      wait_clk(4);
      ser_clk = 1'b1;
      m_sh = {m_sh[22:0], v[i]};
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic strobe();
    pulses = 0;
    ser_le = 1'b1;
    wait_clk(8);
    ser_le = 1'b0;
    wait_clk(6);
    case (m_sh[1:0])
      2'b00: e_r = m_sh[15:2];
      2'b01: begin e_a = m_sh[7:2]; e_b = m_sh[20:8]; e_g = m_sh[21]; end
      default: begin
        e_pd = m_sh[2]; e_as = m_sh[3];
        e_c1 = m_sh[6:4]; e_c2 = m_sh[9:7]; e_ps = m_sh[23:22];
      end
    endcase
  endtask

  task automatic check_all(input string tag, input int exp_pulses);
    chk({tag, " R2 r_div"}, 32'(r_div), 32'(e_r));
    chk({tag, " R3 a_cnt"}, 32'(a_cnt), 32'(e_a));
    chk({tag, " R3 b_cnt"}, 32'(b_cnt), 32'(e_b));
    chk({tag, " R3 cp_gain"}, 32'(cp_gain), 32'(e_g));
    chk({tag, " R4 presc"}, 32'(presc_sel), 32'(e_ps));
    chk({tag, " R4 pd"}, 32'({pd_en, pd_async}), 32'({e_pd, e_as}));
    chk({tag, " R4 cur"}, 32'({cur_set1, cur_set2}), 32'({e_c1, e_c2}));
    chk({tag, " R6 pulses"}, 32'(pulses), 32'(exp_pulses));
  endtask

  task automatic write_word(input logic [23:0] w, input string tag);
    send_bits(64'(w), 24);
    strobe();
    check_all(tag, (w[1:0] == 2'b11) ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b0;
    m_sh = '0; e_r = '0; e_a = '0; e_b = '0; e_g = 1'b0;
    e_ps = '0; e_pd = 1'b0; e_as = 1'b0; e_c1 = '0; e_c2 = '0;
    wait_clk(4);
    check_all("R9 reset", 0);
    chk("R9 cnt_rst", 32'(cnt_rst), 32'd0);
    rst_n = 1'b1;
    wait_clk(3);

    for (int i = 0; i < 14; i++)
      write_word({8'h5A, 14'(1 << i), 2'b00}, "R2 R7 walk");
    write_word({8'hFF, 14'h3FFF, 2'b00}, "R2 ones");
    write_word({8'h00, 14'h2AAA, 2'b00}, "R2 alt");

    for (int a = 0; a < 64; a += 9)
      for (int k = 0; k < 3; k++)
        write_word({2'b10, k[0], 13'((a * 311 + k * 4099) & 13'h1FFF), 6'(a), 2'b01},
                   "R3 R7 ab");

    for (int f = 0; f < 16; f++)
      write_word({f[3:2], 12'hA5C, 3'(f * 3), 3'(f + 2), f[1], f[0], 2'b10}, "R4 func");

    write_word({2'b11, 12'h000, 3'd5, 3'd6, 1'b1, 1'b0, 2'b11}, "R5 init");
    write_word({2'b01, 12'hFFF, 3'd1, 3'd2, 1'b0, 1'b1, 2'b11}, "R5 init2");
    write_word({2'b00, 12'h123, 3'd7, 3'd0, 1'b1, 1'b1, 2'b10}, "R6 func nopulse");

    send_bits(64'h0_BEEF, 20);
    strobe();
    check_all("R8 short", (m_sh[1:0] == 2'b11) ? 1 : 0);
    send_bits(64'h2A_1357_9BDD, 30);
    strobe();
    check_all("R8 long", (m_sh[1:0] == 2'b11) ? 1 : 0);

    send_bits(64'({8'h00, 14'h1234, 2'b00}), 24);
    chk("R10 no strobe r_div", 32'(r_div), 32'(e_r));
    chk("R10 no strobe pulses", 32'(cnt_rst), 32'd0);
    strobe();
    check_all("R1 after strobe", 0);
    chk("R1 r value", 32'(r_div), 32'h1234);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule